// File: doc/BRIEF.md
# Clock-Synchronous Serial I/O Unit

This block is an 8-bit full-duplex synchronous serial port. One shift register sends a byte and receives a byte in the same transfer. A host writes a byte to the data register to start a transfer. When all eight bits have moved, the host reads the received byte from the same address. A completion interrupt request and a done flag report the end of each transfer. The host reads both flags and clears them through a status register.

A control register selects the following:
- the source of the transfer clock: an internal divider, or an external clock that the block synchronizes;
- the clock polarity, which sets both the shift and sample edges and the idle level of the clock;
- the bit order;
- whether the data output pin is driven;
- whether the clock pin acts as the serial clock.

With the internal clock, the start of a transfer waits for the next phase boundary of the divider. After the last bit, the data output floats. The external clock must be slower than one quarter of the system clock.

Register map on `bus_addr`:
- 0: data. A write starts a transfer. A read returns the received byte.
- 1: control. The bits are listed in R2, R6 and R7.
- 2: half-period divide value `div`.
- 3: status. Bit 0 is the interrupt request and bit 1 is the done flag. Both clear on a write of 1.

Top module: `sync_serial_port`

## Requirements
- R1: Every transfer moves exactly 8 bits. With control bit 2 = 0 the first bit sent and received is bit 0 (LSB first). With control bit 2 = 1 the first bit is bit 7 (MSB first). The received byte is read back at address 0.
- R2: With control bit 1 (polarity) = 0, `sdo_o` changes only on falling edges of the transfer clock and `sdi_i` is sampled on rising edges. With polarity = 1 both edges are swapped.
- R3: With the internal clock (control bit 0 = 1), each half-period of `sclk_o` during a transfer lasts `div`+1 system clocks, where `div` is the value at address 2.
- R4: With the internal clock, `sclk_o` rests high between transfers when polarity = 0 and rests low when polarity = 1.
- R5: With the internal clock, the first clock edge of a transfer comes at most 1.5 transfer-clock periods, 3*(`div`+1) system clocks, after the data write.
- R6: `sclk_oe` is 1 only when control bit 0 = 1 and control bit 4 = 1. With the external clock (control bit 0 = 0) and control bit 4 = 0, edges on `sclk_i` are ignored and the transfer does not advance.
- R7: When control bit 3 = 1, `sdo_oe` behaves as follows. With the internal clock it is high from the first clock edge until the eighth bit has been sampled, then low. With the external clock it is always high. When control bit 3 = 0, `sdo_oe` is 0.
- R8: Completion sets status bit 0 (`irq_o`) and status bit 1 (done). Writing 1 to a status bit clears that bit. Starting a new transfer clears done.
- R9: A data write while a transfer is pending or running is ignored. The byte sent is the one written first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational on address) |
| sclk_i | input | 1 | Clock pin input value (external clock) |
| sclk_o | output | 1 | Clock pin output value |
| sclk_oe | output | 1 | Clock pin output enable |
| sdi_i | input | 1 | Serial data input |
| sdo_o | output | 1 | Serial data output value |
| sdo_oe | output | 1 | Serial data output enable (0 = high impedance) |
| irq_o | output | 1 | Completion interrupt request |

## Verification
The assertions assume the following about the inputs:
- The host does not rewrite the control or divider registers while a transfer is running.
- With the external clock, each level of `sclk_i` lasts at least two system clocks, so the synchronizer sees every edge.

The bench writes the configuration only while the port is idle. It holds each external clock level for six system clocks. It changes `sdi_i` only on the launch edges of the transfer clock it observes or drives, so every sample the design takes falls on settled data.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_ARMED = 2'd1,
        SH_RUN   = 2'd2
    } sh_state_e;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_CTRL = 2'd1,
        REG_DIV  = 2'd2,
        REG_STAT = 2'd3
    } reg_addr_e;

    // Control register fields; clk_int sits at bit 0, clk_pin_en at bit 4.
    typedef struct packed {
        logic clk_pin_en;
        logic dout_en;
        logic msb_first;
        logic pol;
        logic clk_int;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/ssp_clkgen.sv
// Free-running half-period divider for the internal transfer clock.
module ssp_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o,
    output logic             phase_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             ph;
    } cg_t;

    cg_t cg_q, cg_d;

    always_comb begin
        cg_d   = cg_q;
        tick_o = (cg_q.cnt >= div_i);
        if (tick_o) begin
            cg_d.cnt = '0;
            cg_d.ph  = ~cg_q.ph;
        end else begin
            cg_d.cnt = cg_q.cnt + DIV_W'(1);
        end
    end

    assign phase_o = cg_q.ph;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cg_q <= '0;
        else        cg_q <= cg_d;
    end

endmodule

// File: rtl/ssp_extsync.sv
// Two-flop synchronizer plus edge detector for an external transfer clock.
module ssp_extsync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } es_t;

    es_t es_q, es_d;

    always_comb begin
        es_d.s1 = pin_i;
        es_d.s2 = es_q.s1;
        es_d.s3 = es_q.s2;
        rise_o  = es_q.s2 & ~es_q.s3;
        fall_o  = ~es_q.s2 & es_q.s3;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) es_q <= '0;
        else        es_q <= es_d;
    end

endmodule

// File: rtl/ssp_shifter.sv
// Shared transmit/receive shift engine driven by launch/capture events.
module ssp_shifter
    import ssp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] tx_i,
    input  logic              ext_mode_i,
    input  logic              launch_i,
    input  logic              capture_i,
    input  logic              msb_first_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic              idle_o,
    output logic              run_o,
    output logic              clk_act_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rx_o
);

    localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

    typedef struct packed {
        sh_state_e         st;
        logic [DATA_W-1:0] sr;
        logic              cap;
        logic [CW-1:0]     cnt;
        logic              skip;
        logic              clk_act;
    } sh_t;

    sh_t sh_q, sh_d;

    always_comb begin
        sh_d   = sh_q;
        done_o = 1'b0;
        rx_o   = msb_first_i ? {sh_q.sr[DATA_W-2:0], sdi_i}
                             : {sdi_i, sh_q.sr[DATA_W-1:1]};
        unique case (sh_q.st)
            SH_IDLE: begin
                if (load_i) begin
                    sh_d.sr      = tx_i;
                    sh_d.cnt     = '0;
                    sh_d.clk_act = 1'b0;
                    sh_d.skip    = ext_mode_i;
                    sh_d.st      = ext_mode_i ? SH_RUN : SH_ARMED;
                end
            end
            SH_ARMED: begin
                if (launch_i) begin
                    sh_d.st      = SH_RUN;
                    sh_d.skip    = 1'b0;
                    sh_d.clk_act = 1'b1;
                end
            end
            SH_RUN: begin
                if (launch_i) begin
                    sh_d.clk_act = 1'b1;
                    if (sh_q.skip) begin
                        sh_d.skip = 1'b0;
                    end else if (msb_first_i) begin
                        sh_d.sr = {sh_q.sr[DATA_W-2:0], sh_q.cap};
                    end else begin
                        sh_d.sr = {sh_q.cap, sh_q.sr[DATA_W-1:1]};
                    end
                end else if (capture_i) begin
                    sh_d.clk_act = 1'b0;
                    sh_d.cap     = sdi_i;
                    if (sh_q.cnt == LAST) begin
                        done_o  = 1'b1;
                        sh_d.st = SH_IDLE;
                    end else begin
                        sh_d.cnt = sh_q.cnt + CW'(1);
                    end
                end
            end
            default: sh_d.st = SH_IDLE;
        endcase
    end

    assign sdo_o     = msb_first_i ? sh_q.sr[DATA_W-1] : sh_q.sr[0];
    assign idle_o    = (sh_q.st == SH_IDLE);
    assign run_o     = (sh_q.st == SH_RUN);
    assign clk_act_o = sh_q.clk_act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            sh_q.st <= SH_IDLE;
        end else begin
            sh_q <= sh_d;
        end
    end

endmodule

// File: rtl/sync_serial_port.sv
// Register file, clock selection and pin control of the serial port.
module sync_serial_port
    import ssp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sclk_i,
    output logic              sclk_o,
    output logic              sclk_oe,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic              sdo_oe,
    output logic              irq_o
);

    typedef struct packed {
        logic [DATA_W-1:0] ctrl_raw;
        logic [DIV_W-1:0]  div;
        logic [DATA_W-1:0] rx;
        logic              irq;
        logic              done;
    } top_t;

    top_t  rg_q, rg_d;
    ctrl_t ctrl;

    logic              tick, phase, ext_rise, ext_fall;
    logic              launch_evt, capture_evt, load;
    logic              sh_idle, sh_run, sh_clk_act, sh_done, sh_sdo;
    logic [DATA_W-1:0] sh_rx;
    logic              int_mode, pol_w;

    assign ctrl     = ctrl_t'(rg_q.ctrl_raw[CTRL_W-1:0]);
    assign int_mode = ctrl.clk_int;
    assign pol_w    = ctrl.pol;

    ssp_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_i   (rg_q.div),
        .tick_o  (tick),
        .phase_o (phase)
    );

    ssp_extsync u_extsync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (sclk_i),
        .rise_o (ext_rise),
        .fall_o (ext_fall)
    );

    // Launch = edge where data changes; capture = edge where data is sampled.
    always_comb begin
        if (int_mode) begin
            launch_evt  = tick & ~phase;
            capture_evt = tick & phase;
        end else begin
            launch_evt  = ctrl.clk_pin_en & (ctrl.pol ? ext_rise : ext_fall);
            capture_evt = ctrl.clk_pin_en & (ctrl.pol ? ext_fall : ext_rise);
        end
    end

    ssp_shifter #(.DATA_W(DATA_W)) u_shifter (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .tx_i        (bus_wdata),
        .ext_mode_i  (~int_mode),
        .launch_i    (launch_evt),
        .capture_i   (capture_evt),
        .msb_first_i (ctrl.msb_first),
        .sdi_i       (sdi_i),
        .sdo_o       (sh_sdo),
        .idle_o      (sh_idle),
        .run_o       (sh_run),
        .clk_act_o   (sh_clk_act),
        .done_o      (sh_done),
        .rx_o        (sh_rx)
    );

    always_comb begin
        rg_d = rg_q;
        load = 1'b0;
        if (bus_wr) begin
            unique case (reg_addr_e'(bus_addr))
                REG_DATA: load = sh_idle;
                REG_CTRL: rg_d.ctrl_raw = bus_wdata;
                REG_DIV:  rg_d.div = bus_wdata[DIV_W-1:0];
                REG_STAT: begin
                    if (bus_wdata[0]) rg_d.irq  = 1'b0;
                    if (bus_wdata[1]) rg_d.done = 1'b0;
                end
                default: ;
            endcase
        end
        if (load) rg_d.done = 1'b0;
        if (sh_done) begin
            rg_d.rx   = sh_rx;
            rg_d.irq  = 1'b1;
            rg_d.done = 1'b1;
        end
    end

    always_comb begin
        unique case (reg_addr_e'(bus_addr))
            REG_DATA: bus_rdata = rg_q.rx;
            REG_CTRL: bus_rdata = rg_q.ctrl_raw;
            REG_DIV:  bus_rdata = DATA_W'(rg_q.div);
            REG_STAT: bus_rdata = DATA_W'({rg_q.done, rg_q.irq});
            default:  bus_rdata = '0;
        endcase
    end

    assign sclk_o  = sh_clk_act ? ctrl.pol : ~ctrl.pol;
    assign sclk_oe = int_mode & ctrl.clk_pin_en;
    assign sdo_o   = sh_sdo;
    assign sdo_oe  = ctrl.dout_en & (int_mode ? sh_run : 1'b1);
    assign irq_o   = rg_q.irq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
    input logic clk,
    input logic rst_n,
    input logic int_mode,
    input logic pol,
    input logic sh_idle,
    input logic sh_run,
    input logic launch,
    input logic done_pulse,
    input logic sclk_o,
    input logic sdo_o,
    input logic sdo_oe,
    input logic irq_o
);

    assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (int_mode && sh_idle) |-> (sclk_o == !pol));

    assert_float_when_not_running_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (int_mode && !sh_run) |-> !sdo_oe);

    assert_irq_from_completion_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(done_pulse));

    assert_sdo_only_on_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_run && $past(sh_run) && !$past(launch)) |-> $stable(sdo_o));

    assert_done_leaves_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !sh_run);

endmodule

bind sync_serial_port ssp_checker u_ssp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .int_mode   (int_mode),
    .pol        (pol_w),
    .sh_idle    (sh_idle),
    .sh_run     (sh_run),
    .launch     (launch_evt),
    .done_pulse (sh_done),
    .sclk_o     (sclk_o),
    .sdo_o      (sdo_o),
    .sdo_oe     (sdo_oe),
    .irq_o      (irq_o)
);

// File: tb/tb_sync_serial_port.sv
`timescale 1ns/1ps
module tb_sync_serial_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       sclk_i = 1'b1;
    logic       sclk_o, sclk_oe, sdi_i, sdo_o, sdo_oe, irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    initial sdi_i = 1'b0;

    always #2 clk = ~clk;

    sync_serial_port dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk_i(sclk_i),
        .sclk_o(sclk_o), .sclk_oe(sclk_oe), .sdi_i(sdi_i), .sdo_o(sdo_o),
        .sdo_oe(sdo_oe), .irq_o(irq_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_checks = n_checks + 1;
            n_fail   = n_fail + 1;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    function automatic logic pick(input logic [7:0] b, input logic ms, input int i);
        return ms ? b[7-i] : b[i];
    endfunction

    // Internally clocked transfer with the bench acting as the far-end device.
    task automatic run_int(input logic [7:0] tx, input logic [7:0] slv, input int dv,
                           input logic pl, input logic ms, input logic poke);
        int t = 0, last = 0, nl = 0, nc = 0, lat = -1, bad_hp = 0, bad_r2 = 0;
        logic prev_clk, prev_sdo, oe_bad;
        logic [7:0] got = 8'd0, rd;
        oe_bad = 1'b0;
        bus_write(2'd2, 8'(dv));
        bus_write(2'd1, {3'b000, 1'b1, 1'b1, ms, pl, 1'b1});
        chk(sclk_o === ~pl, "R4 idle clock level before start", int'(sclk_o), int'(~pl));
        chk(sdo_oe === 1'b0, "R7 data pin floats before start", int'(sdo_oe), 0);
        chk(sclk_oe === 1'b1, "R6 clock pin driven internal", int'(sclk_oe), 1);
        sdi_i = pick(slv, ms, 0);
        bus_write(2'd0, tx);
        prev_clk = sclk_o; prev_sdo = sdo_o;
        while (nc < 8 && t < 64 * (dv + 1)) begin
            if (poke && t == 1) begin
                bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = ~tx;
            end else begin
                bus_wr = 1'b0;
            end
            @(negedge clk);
            t++;
            if (sclk_o !== prev_clk) begin
                if (sclk_o === pl) begin
                    if (nl == 0) lat = t;
                    else begin
                        if (t - last != dv + 1) bad_hp++;
                        sdi_i = pick(slv, ms, nl);
                    end
                    if (sdo_oe !== 1'b1) oe_bad = 1'b1;
                    nl++;
                end else begin
                    if (t - last != dv + 1) bad_hp++;
                    if (ms) got[7-nc] = sdo_o; else got[nc] = sdo_o;
                    nc++;
                end
                last = t;
            end else if (sdo_o !== prev_sdo && nl > 0) begin
                bad_r2++;
            end
            prev_clk = sclk_o; prev_sdo = sdo_o;
        end
        bus_wr = 1'b0;
        chk(nc == 8 && nl == 8, "R1 eight clock periods per transfer", nc, 8);
        chk(bad_hp == 0, "R3 half period equals div+1", bad_hp, 0);
        chk(lat >= 1 && lat <= 3 * (dv + 1), "R5 start latency", lat, 3 * (dv + 1));
        chk(bad_r2 == 0, "R2 data changes only on launch edge", bad_r2, 0);
        chk(!oe_bad, "R7 data pin driven during transfer", int'(oe_bad), 0);
        chk(got == tx, poke ? "R9 write during transfer ignored" : "R1 R2 transmitted byte",
            got, tx);
        repeat (2) @(negedge clk);
        chk(sdo_oe === 1'b0, "R7 data pin floats after last bit", int'(sdo_oe), 0);
        chk(sclk_o === ~pl, "R4 idle clock level after end", int'(sclk_o), int'(~pl));
        bus_read(2'd0, rd);
        chk(rd == slv, "R1 R2 received byte", rd, slv);
        bus_read(2'd3, rd);
        chk(rd == 8'd3 && irq_o === 1'b1, "R8 completion flags", rd, 3);
        bus_write(2'd3, 8'd1);
        bus_read(2'd3, rd);
        chk(rd == 8'd2 && irq_o === 1'b0, "R8 clear irq only", rd, 2);
        bus_write(2'd3, 8'd2);
        bus_read(2'd3, rd);
        chk(rd == 8'd0, "R8 clear done", rd, 0);
    endtask

    // Externally clocked transfer; pin_en=0 first shows edges being ignored.
    task automatic run_ext(input logic [7:0] tx, input logic [7:0] slv, input logic pl,
                           input logic ms, input logic pin_en);
        logic [7:0] got = 8'd0, rd;
        logic cur_en;
        cur_en = pin_en;
        bus_write(2'd1, {3'b000, pin_en, 1'b1, ms, pl, 1'b0});
        sclk_i = ~pl;
        repeat (4) @(negedge clk);
        chk(sclk_oe === 1'b0, "R6 clock pin input in external mode", int'(sclk_oe), 0);
        chk(sdo_oe === 1'b1, "R7 data pin driven in external mode", int'(sdo_oe), 1);
        sdi_i = pick(slv, ms, 0);
        bus_write(2'd0, tx);
        repeat (4) @(negedge clk);
        for (int pass = 0; pass < 2; pass++) begin
            for (int i = 0; i < 8; i++) begin
                sclk_i = pl;
                if (i > 0 && cur_en) sdi_i = pick(slv, ms, i);
                repeat (6) @(negedge clk);
                if (ms) got[7-i] = sdo_o; else got[i] = sdo_o;
                sclk_i = ~pl;
                repeat (6) @(negedge clk);
            end
            if (cur_en) break;
            bus_read(2'd3, rd);
            chk(rd == 8'd0, "R6 external edges ignored with clock pin off", rd, 0);
            chk(got == {8{pick(tx, ms, 0)}}, "R6 output held with clock pin off",
                got, {8{pick(tx, ms, 0)}});
            cur_en = 1'b1;
            bus_write(2'd1, {3'b000, 1'b1, 1'b1, ms, pl, 1'b0});
            repeat (4) @(negedge clk);
        end
        chk(got == tx, "R1 R2 external transmitted byte", got, tx);
        bus_read(2'd0, rd);
        chk(rd == slv, "R1 R2 external received byte", rd, slv);
        bus_read(2'd3, rd);
        chk(rd == 8'd3, "R8 external completion flags", rd, 3);
        bus_write(2'd3, 8'd3);
    endtask

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        bus_read(2'd3, rd);
        chk(rd == 8'd0 && irq_o === 1'b0, "R8 reset status", rd, 0);
        bus_read(2'd0, rd);
        chk(rd == 8'd0, "R1 reset receive byte", rd, 0);
        chk(sclk_oe === 1'b0 && sdo_oe === 1'b0, "R6 R7 reset pins released",
            int'({sclk_oe, sdo_oe}), 0);

        bus_write(2'd1, 8'b0000_1001);
        @(negedge clk);
        chk(sclk_oe === 1'b0, "R6 clock pin off in internal mode", int'(sclk_oe), 0);

        for (int dv = 0; dv < 4; dv++)
            for (int pl = 0; pl < 2; pl++)
                for (int ms = 0; ms < 2; ms++) begin
                    int k = dv * 4 + pl * 2 + ms;
                    logic [7:0] tx  = 8'(8'h35 ^ (k * 37));
                    logic [7:0] slv = {tx[2:0], tx[7:3]} ^ 8'h5A;
                    run_int(tx, slv, dv, 1'(pl), 1'(ms), 1'b0);
                end
        run_int(8'h00, 8'hFF, 1, 1'b0, 1'b0, 1'b0);
        run_int(8'hFF, 8'h00, 2, 1'b1, 1'b1, 1'b0);
        run_int(8'hA5, 8'h3C, 2, 1'b0, 1'b0, 1'b1);
        run_int(8'h81, 8'h7E, 0, 1'b1, 1'b1, 1'b1);

        for (int pl = 0; pl < 2; pl++)
            for (int ms = 0; ms < 2; ms++)
                run_ext(8'(8'hC6 ^ (pl * 8'h11) ^ (ms * 8'h42)), 8'(8'h1D + pl * 8'h30 + ms),
                        1'(pl), 1'(ms), 1'b1);
        run_ext(8'hB4, 8'h69, 1'b0, 1'b0, 1'b0);
        run_ext(8'h4B, 8'h96, 1'b1, 1'b1, 1'b0);

        bus_write(2'd1, 8'b0001_0001);
        @(negedge clk);
        chk(sdo_oe === 1'b0, "R7 data output disabled", int'(sdo_oe), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule